// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave holds stuck, typically with SDA pulled low partway through a byte. A single-cycle start request makes it take over the open-drain pull-down enables of SCL and SDA from the normal master core. It then plays a fixed recovery pattern on the bus:

1. Both lines are released.
2. SCL is clocked nine times.
3. SDA is pulled low while SCL is high.
4. SDA is released, which forms a STOP.
5. The line enables are handed back to the master core.

Each bus step lasts a fixed number of system clocks, set by a parameter. The default of 500 clocks gives about 10 µs per step at 50 MHz.

Outside a sequence, the block is transparent and passes the core's enables straight to the pads. A busy flag covers the whole override. A one-cycle done pulse marks the hand-back. A status flag reports whether SDA read high at the end of the STOP step, which tells the caller whether the slave let go. Deciding when the bus is hung is left to the logic that raises the start request.

Top module: `i2c_bus_unjam`

## Requirements
- R1: While busy_o is low, scl_oe_o equals core_scl_oe_i and sda_oe_o equals core_sda_oe_i in the same cycle. An enable of 1 pulls the line low; 0 releases it.
- R2: A start_i seen high at a clock edge while idle raises busy_o from that edge. For the next STEP_CYC cycles, both scl_oe_o and sda_oe_o are 0.
- R3: Next come PULSES SCL pulses (default nine). Each pulse has scl_oe_o at 1 for STEP_CYC cycles, then at 0 for STEP_CYC cycles. sda_oe_o stays 0 throughout.
- R4: After the last pulse, sda_oe_o is 1 and scl_oe_o is 0 for STEP_CYC cycles.
- R5: Next, both enables are 0 for STEP_CYC cycles, which forms a STOP.
- R6: Next comes one cycle in which busy_o is still high but the enables already follow the core inputs. In total, busy_o stays high for (2*PULSES+3)*STEP_CYC+1 cycles.
- R7: done_o is high for exactly one cycle, the cycle right after the hand-back cycle, and busy_o is low in that cycle.
- R8: start_i is ignored while busy_o is high, including in the hand-back cycle. The sequence is neither restarted nor extended.
- R9: sda_free_o resets to 0. It loads the value of sda_in_i from the last cycle of the STOP step. It holds that value until the next sequence reaches the same point.
- R10: The block never pulls SCL and SDA low together while it owns the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Recovery request, sampled at each clock edge |
| core_scl_oe_i | input | 1 | SCL pull-down enable from the master core |
| core_sda_oe_i | input | 1 | SDA pull-down enable from the master core |
| sda_in_i | input | 1 | Synchronized SDA pad level |
| scl_oe_o | output | 1 | SCL pull-down enable to the pad (1 = drive low) |
| sda_oe_o | output | 1 | SDA pull-down enable to the pad (1 = drive low) |
| busy_o | output | 1 | High while the recovery sequence runs |
| done_o | output | 1 | One-cycle pulse after the hand-back |
| sda_free_o | output | 1 | SDA was high at the end of the last STOP step |

## Verification
A step counter that slips by one cycle shifts every later pad edge. The pad enables are compared with the expected pattern on every cycle, so such an error shows within one step of where the count diverges. A wrong pulse count, or a wrong state after the last pulse, appears as an extra or missing SCL low period, or as SDA pulled early. It also shows in the total busy length at the done pulse. A stray restart, or a sequence that never hands the lines back, shows as busy_o still high or as enables that ignore the core inputs once the expected done cycle has passed.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_SCL_LO,
        ST_SCL_HI,
        ST_SDA_LO,
        ST_STOP,
        ST_RESTORE
    } unjam_state_e;

    typedef struct packed {
        unjam_state_e state;
        logic         sda_free;
        logic         done;
    } unjam_regs_t;

endpackage

// File: rtl/unjam_step_timer.sv
module unjam_step_timer #(
    parameter int unsigned STEP_CYC = 500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/unjam_pulse_ctr.sv
module unjam_pulse_ctr #(
    parameter int unsigned PULSES = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned PW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [PW-1:0] LAST = PW'(PULSES - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
    import unjam_pkg::*;
#(
    parameter int unsigned STEP_CYC = 500,
    parameter int unsigned PULSES   = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic core_scl_oe_i,
    input  logic core_sda_oe_i,
    input  logic sda_in_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic sda_free_o
);
    localparam unjam_regs_t REGS_RST = '{state: ST_IDLE, sda_free: 1'b0, done: 1'b0};

    unjam_regs_t r_d, r_q;
    logic        step_run;
    logic        step_tick;
    logic        pulse_last;
    logic        own;
    logic        scl_pull;
    logic        sda_pull;

    assign step_run = (r_q.state != ST_IDLE) && (r_q.state != ST_RESTORE);

    unjam_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (step_run),
        .tick_o (step_tick)
    );

    unjam_pulse_ctr #(.PULSES(PULSES)) u_pulses (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (r_q.state == ST_IDLE),
        .inc_i   (step_tick && (r_q.state == ST_SCL_HI)),
        .last_o  (pulse_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE:    if (start_i)   r_d.state = ST_RELEASE;
            ST_RELEASE: if (step_tick) r_d.state = ST_SCL_LO;
            ST_SCL_LO:  if (step_tick) r_d.state = ST_SCL_HI;
            ST_SCL_HI:  if (step_tick) r_d.state = pulse_last ? ST_SDA_LO : ST_SCL_LO;
            ST_SDA_LO:  if (step_tick) r_d.state = ST_STOP;
            ST_STOP: begin
                if (step_tick) begin
                    r_d.state    = ST_RESTORE;
                    r_d.sda_free = sda_in_i;
                end
            end
            ST_RESTORE: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= REGS_RST;
        else         r_q <= r_d;
    end

    // Ownership mux: override pattern while stepping, core drive otherwise.
    always_comb begin
        own      = step_run;
        scl_pull = (r_q.state == ST_SCL_LO);
        sda_pull = (r_q.state == ST_SDA_LO);
        scl_oe_o = own ? scl_pull : core_scl_oe_i;
        sda_oe_o = own ? sda_pull : core_sda_oe_i;
    end

    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = r_q.done;
    assign sda_free_o = r_q.sda_free;

endmodule

// File: rtl/unjam_checker.sv
module unjam_checker #(
    parameter int unsigned PULSES = 9
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic core_scl_oe_i,
    input logic core_sda_oe_i,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic sda_free_o
);
    logic       prev_scl;
    logic       prev_busy;
    logic [7:0] rel_cnt;

    // Counts SCL releases (pull 1 -> 0) seen during a running sequence.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_scl  <= 1'b0;
            prev_busy <= 1'b0;
            rel_cnt   <= '0;
        end else begin
            prev_scl  <= scl_oe_o;
            prev_busy <= busy_o;
            if (start_i && !busy_o) begin
                rel_cnt <= '0;
            end else if (busy_o && prev_busy && prev_scl && !scl_oe_o) begin
                rel_cnt <= rel_cnt + 8'd1;
            end
        end
    end

    p_idle_passthru_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (scl_oe_o == core_scl_oe_i && sda_oe_o == core_sda_oe_i));

    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    p_pulse_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (rel_cnt == 8'(PULSES)));

    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_at_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !$past(busy_o)) |-> $stable(sda_free_o));

    p_no_dual_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && scl_oe_o && sda_oe_o) |=> !busy_o);

endmodule

bind i2c_bus_unjam unjam_checker #(.PULSES(PULSES)) u_unjam_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .core_scl_oe_i (core_scl_oe_i),
    .core_sda_oe_i (core_sda_oe_i),
    .scl_oe_o      (scl_oe_o),
    .sda_oe_o      (sda_oe_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .sda_free_o    (sda_free_o)
);

// File: tb/test_i2c_bus_unjam.sv
module test_i2c_bus_unjam;
    localparam int STEP   = 4;
    localparam int PULSES = 9;
    localparam int TOTAL  = (2 * PULSES + 3) * STEP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic core_scl = 1'b0;
    logic core_sda = 1'b0;
    logic sda_in = 1'b1;
    logic scl_oe, sda_oe, busy, done, sda_free;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic flag_model = 1'b0;

    always #10 clk = ~clk;

    i2c_bus_unjam #(.STEP_CYC(STEP), .PULSES(PULSES)) i_i2c_bus_unjam (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .core_scl_oe_i (core_scl),
        .core_sda_oe_i (core_sda),
        .sda_in_i      (sda_in),
        .scl_oe_o      (scl_oe),
        .sda_oe_o      (sda_oe),
        .busy_o        (busy),
        .done_o        (done),
        .sda_free_o    (sda_free)
    );

    // Expected behaviour n cycles after the edge that accepted the start.
    function automatic logic exp_own(int n);
        return n < TOTAL;
    endfunction

    function automatic logic exp_scl_pull(int n);
        int ph = n / STEP;
        return (n < TOTAL) && ph >= 1 && ph <= 2 * PULSES && (ph % 2 == 1);
    endfunction

    function automatic logic exp_sda_pull(int n);
        return (n < TOTAL) && (n / STEP == 2 * PULSES + 1);
    endfunction

    function automatic string tag_of(int n);
        int ph = n / STEP;
        if (n == TOTAL + 1)          return "R7";
        if (n == TOTAL)              return "R6";
        if (ph == 0)                 return "R2";
        if (ph <= 2 * PULSES)        return "R3";
        if (ph == 2 * PULSES + 1)    return "R4";
        return "R5";
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp_v);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(scl_oe == core_scl, tag, scl_oe, core_scl);
        chk(sda_oe == core_sda, tag, sda_oe, core_sda);
        chk(busy == 1'b0, tag, busy, 0);
        chk(sda_free == flag_model, "R9", sda_free, flag_model);
    endtask

    // mode 0: no stray starts, 1: random stray starts, 2: start held high
    task automatic run_seq(input int mode);
        logic sval = 1'($urandom);
        sda_in = sval;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        for (int n = 0; n <= TOTAL + 1; n++) begin
            logic es, ed;
            string t;
            @(negedge clk);
            t  = tag_of(n);
            es = exp_own(n) ? exp_scl_pull(n) : core_scl;
            ed = exp_own(n) ? exp_sda_pull(n) : core_sda;
            chk(scl_oe == es, t, scl_oe, es);
            chk(sda_oe == ed, t, sda_oe, ed);
            chk(busy == (n <= TOTAL), t, busy, (n <= TOTAL));
            chk(done == (n == TOTAL + 1), t, done, (n == TOTAL + 1));
            core_scl = 1'($urandom);
            core_sda = 1'($urandom);
            if (n <= TOTAL && mode == 1)      start = ($urandom % 4 == 0);
            else if (n <= TOTAL && mode == 2) start = 1'b1;
            else                              start = 1'b0;
        end
        flag_model = sval;
        chk(sda_free == sval, "R9", sda_free, sval);
        @(negedge clk);
        chk(busy == 1'b0, "R8", busy, 0);
        chk(done == 1'b0, "R8", done, 0);
        chk(scl_oe == core_scl, "R8", scl_oe, core_scl);
    endtask

    task automatic idle_window(input int len);
        for (int k = 0; k < len; k++) begin
            core_scl = 1'($urandom);
            core_sda = 1'($urandom);
            sda_in   = 1'($urandom);
            #1;
            check_idle("R1");
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        core_scl = 1'b1;
        core_sda = 1'b0;
        #1;
        chk(busy == 1'b0 && done == 1'b0, "R1", busy, 0);
        chk(sda_free == 1'b0, "R9", sda_free, 0);
        chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R1", {scl_oe, sda_oe}, 2);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_window(3);
        run_seq(0);
        idle_window(2);
        run_seq(2);
        // back-to-back: new start right after the done pulse
        run_seq(0);
        for (int r = 0; r < 10; r++) begin
            run_seq(1);
            idle_window(1 + int'($urandom % 4));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule